// File: doc/BRIEF.md
# Byte-serial DMA address loader

This block is the register front end of a small DMA engine that serves one SCSI controller. Software does not write a wide address register in one access. It first writes the top byte of a 32-bit command word to a latch register. It then sends the remaining bytes, most significant first, to a single byte-wide address register. Bit 31 of the command word gives the transfer direction. Bits 30..0 hold a word address, meaning the byte address shifted right by one.

The block decodes the two register offsets and counts the bytes as they arrive. When the last byte lands, it hands the datapath a byte address, a direction bit and a one-cycle "loaded" strobe. The layout is chosen by one parameter. In variant 0 the latch is at offset 0x8000 and the top byte is sent again through the address register. In variant 1 the latch is at offset 0x10 and only three bytes follow it. A separate path limits the transfer length passed downstream to 24 bits. Address bytes that arrive with no latch write in front of them are flagged. A new latch write in the middle of a sequence starts the load over.

Top module: `dma_addr_loader`

## Requirements
- R1: While `rst_n` is low (asynchronous assertion), and after it is released, `load_done`, `dma_addr`, `dma_dir` and `seq_error` are 0 and no load is in progress.
- R2: A write to the latch offset arms a new load, stores the data byte as word bits 31..24 and clears `seq_error` on the next cycle. The latch offset is 0x8000 for VARIANT 0 and 0x0010 for VARIANT 1.
- R3: Writes to the address offset 0x0000 fill the word most significant byte first. VARIANT 0 takes four bytes (31..24, 23..16, 15..8, 7..0), and its first byte replaces the latched top byte. VARIANT 1 takes three bytes (23..16, 15..8, 7..0) and keeps the latched top byte.
- R4: `load_done` is high for exactly one cycle. That cycle starts at the clock edge that accepts the final address byte, and only that edge raises it.
- R5: On completion, `dma_addr` = {word[30:0], 0} and `dma_dir` = word[31] (1 = write to memory, 0 = read from memory). Both change in the same cycle that `load_done` is high.
- R6: `dma_addr` and `dma_dir` hold their value in every cycle without `load_done`.
- R7: An address-offset write with no armed load changes no output other than `seq_error`. It sets `seq_error`, which stays set until the next latch write.
- R8: A latch write in the middle of a sequence throws away the bytes already received and restarts the byte count. The earlier partial load never raises `load_done`.
- R9: Writes to any offset other than the address and latch offsets have no effect and do not advance the byte count.
- R10: `len_out` equals `len_in` when `len_in` is at most 2^24-1. Otherwise it is 2^24-1.
- R11: After a load completes the block disarms. A further address byte without a new latch write is treated as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_ofs | input | OFS_W (16) | Register offset of the write |
| bus_wdata | input | 8 | Write data byte |
| len_in | input | LEN_IN_W (32) | Requested transfer length |
| len_out | output | 24 | Length limited to 24 bits |
| load_done | output | 1 | One-cycle strobe when a load completes |
| dma_addr | output | 32 | Byte address of the completed load |
| dma_dir | output | 1 | Direction of the completed load, 1 = write to memory |
| seq_error | output | 1 | Sticky flag for address bytes that arrive with no armed load |

## Verification
The hardest states to reach from the ports are the ones where the byte counter is part-way through a load. The output registers cannot show this position. The stimulus stops a load after one or two bytes and then re-arms it with a new latch write, writes to unrelated offsets, or asserts reset. It then checks whether the next full sequence gives the expected word and whether `load_done` appears after the expected byte and not earlier. A top byte in variant 0 that differs from the latched one shows which of the two copies reaches `dma_dir`.

// File: rtl/dal_pkg.sv
package dal_pkg;

  localparam int unsigned WORD_W     = 32;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned WORD_BYTES = WORD_W / BYTE_W;
  localparam int unsigned LEN_W      = 24;
  localparam int unsigned ADDR_OFS   = 0;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_ADDR  = 2'd1,
    SEL_LATCH = 2'd2
  } reg_sel_e;

  // Latch offset for each register layout variant.
  function automatic int unsigned latch_offset(input int unsigned variant);
    return (variant == 0) ? 32'h0000_8000 : 32'h0000_0010;
  endfunction

  // Number of address-register bytes that follow the latch write.
  function automatic int unsigned addr_bytes(input int unsigned variant);
    return (variant == 0) ? 4 : 3;
  endfunction

endpackage

// File: rtl/dal_rst_sync.sv
module dal_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/dal_decode.sv
module dal_decode
  import dal_pkg::*;
#(
  parameter int unsigned OFS_W     = 16,
  parameter int unsigned LATCH_OFS = 32'h8000
) (
  input  logic             bus_wr,
  input  logic [OFS_W-1:0] bus_ofs,
  output reg_sel_e         sel
);

  localparam logic [OFS_W-1:0] ADDR_V  = OFS_W'(ADDR_OFS);
  localparam logic [OFS_W-1:0] LATCH_V = OFS_W'(LATCH_OFS);

  always_comb begin
    sel = SEL_NONE;
    if (bus_wr) begin
      if (bus_ofs == ADDR_V) begin
        sel = SEL_ADDR;
      end else if (bus_ofs == LATCH_V) begin
        sel = SEL_LATCH;
      end
    end
  end

endmodule

// File: rtl/dal_len_clamp.sv
module dal_len_clamp #(
  parameter int unsigned IN_W  = 32,
  parameter int unsigned OUT_W = 24
) (
  input  logic [IN_W-1:0]  len_in,
  output logic [OUT_W-1:0] len_out
);

  generate
    if (IN_W > OUT_W) begin : g_clamp
      logic over;
      assign over    = |len_in[IN_W-1:OUT_W];
      assign len_out = over ? {OUT_W{1'b1}} : len_in[OUT_W-1:0];
    end else begin : g_pass
      assign len_out = OUT_W'(len_in);
    end
  endgenerate

endmodule

// File: rtl/dal_seq.sv
module dal_seq
  import dal_pkg::*;
#(
  parameter int unsigned N_ADDR = 4,
  localparam int unsigned CNT_W = $clog2(N_ADDR + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  reg_sel_e          sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic              load_done,
  output logic [WORD_W-1:0] dma_addr,
  output logic              dma_dir,
  output logic              seq_error,
  output logic              armed
);

  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(N_ADDR - 1);
  localparam logic [1:0]       TOP_POS  = 2'(N_ADDR - 1);

  // state
  logic              armed_q, armed_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] shadow_q, shadow_d;
  logic              err_q, err_d;
  logic              done_q, done_d;
  logic [WORD_W-1:0] addr_q, addr_d;
  logic              dir_q, dir_d;

  // clock enables
  logic ctl_en;
  logic out_en;

  // byte lane steering
  logic [1:0]            pos;
  logic [WORD_BYTES-1:0] lane_hit;
  logic [WORD_W-1:0]     merged;

  assign pos = TOP_POS - 2'(cnt_q);

  for (genvar b = 0; b < WORD_BYTES; b++) begin : g_lane
    assign lane_hit[b] = (pos == 2'(b));
    assign merged[b*BYTE_W +: BYTE_W] =
      lane_hit[b] ? wdata : shadow_q[b*BYTE_W +: BYTE_W];
  end

  assign addr_d = {merged[WORD_W-2:0], 1'b0};
  assign dir_d  = merged[WORD_W-1];

  // next-state logic
  always_comb begin
    armed_d  = armed_q;
    cnt_d    = cnt_q;
    shadow_d = shadow_q;
    err_d    = err_q;
    done_d   = 1'b0;
    ctl_en   = 1'b0;
    out_en   = 1'b0;
    unique case (sel)
      SEL_LATCH: begin
        ctl_en   = 1'b1;
        armed_d  = 1'b1;
        cnt_d    = '0;
        err_d    = 1'b0;
        shadow_d = {wdata, shadow_q[WORD_W-BYTE_W-1:0]};
      end
      SEL_ADDR: begin
        ctl_en = 1'b1;
        if (!armed_q) begin
          err_d = 1'b1;
        end else begin
          shadow_d = merged;
          if (cnt_q == LAST_CNT) begin
            done_d  = 1'b1;
            out_en  = 1'b1;
            armed_d = 1'b0;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      default: begin
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q  <= 1'b0;
      cnt_q    <= '0;
      shadow_q <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
      addr_q   <= '0;
      dir_q    <= 1'b0;
    end else begin
      done_q <= done_d;
      if (ctl_en) begin
        armed_q  <= armed_d;
        cnt_q    <= cnt_d;
        shadow_q <= shadow_d;
        err_q    <= err_d;
      end
      if (out_en) begin
        addr_q <= addr_d;
        dir_q  <= dir_d;
      end
    end
  end

  assign load_done = done_q;
  assign dma_addr  = addr_q;
  assign dma_dir   = dir_q;
  assign seq_error = err_q;
  assign armed     = armed_q;

endmodule

// File: rtl/dma_addr_loader.sv
module dma_addr_loader
  import dal_pkg::*;
#(
  parameter int unsigned VARIANT  = 0,
  parameter int unsigned OFS_W    = 16,
  parameter int unsigned LEN_IN_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [OFS_W-1:0]    bus_ofs,
  input  logic [BYTE_W-1:0]   bus_wdata,
  input  logic [LEN_IN_W-1:0] len_in,
  output logic [LEN_W-1:0]    len_out,
  output logic                load_done,
  output logic [WORD_W-1:0]   dma_addr,
  output logic                dma_dir,
  output logic                seq_error
);

  localparam int unsigned LATCH_OFS = latch_offset(VARIANT);
  localparam int unsigned N_ADDR    = addr_bytes(VARIANT);

  logic     rst_sync_n;
  reg_sel_e sel;
  logic     armed;

  dal_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  dal_decode #(
    .OFS_W     (OFS_W),
    .LATCH_OFS (LATCH_OFS)
  ) u_decode (
    .bus_wr  (bus_wr),
    .bus_ofs (bus_ofs),
    .sel     (sel)
  );

  dal_seq #(
    .N_ADDR (N_ADDR)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sel       (sel),
    .wdata     (bus_wdata),
    .load_done (load_done),
    .dma_addr  (dma_addr),
    .dma_dir   (dma_dir),
    .seq_error (seq_error),
    .armed     (armed)
  );

  dal_len_clamp #(
    .IN_W  (LEN_IN_W),
    .OUT_W (LEN_W)
  ) u_len (
    .len_in  (len_in),
    .len_out (len_out)
  );

endmodule

// File: rtl/dal_checker.sv
module dal_checker #(
  parameter int unsigned OFS_W     = 16,
  parameter int unsigned LEN_IN_W  = 32,
  parameter int unsigned LATCH_OFS = 32'h8000
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic                bus_wr,
  input logic [OFS_W-1:0]    bus_ofs,
  input logic [LEN_IN_W-1:0] len_in,
  input logic [23:0]         len_out,
  input logic                load_done,
  input logic [31:0]         dma_addr,
  input logic                dma_dir,
  input logic                seq_error,
  input logic                armed
);

  localparam logic [OFS_W-1:0] LATCH_V = OFS_W'(LATCH_OFS);

  logic addr_wr;
  logic latch_wr;
  assign addr_wr  = bus_wr && (bus_ofs == '0);
  assign latch_wr = bus_wr && (bus_ofs == LATCH_V);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_done |=> !load_done); // R4

  AST_DONE_AFTER_ADDR_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_done |-> $past(addr_wr)); // R4

  AST_OUTPUTS_HELD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !load_done |-> ($stable(dma_addr) && $stable(dma_dir))); // R6

  AST_ORPHAN_FLAGGED: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (addr_wr && !armed) |=> (seq_error && !load_done)); // R7

  AST_LATCH_ARMS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    latch_wr |=> (armed && !seq_error)); // R2

  generate
    if (LEN_IN_W > 24) begin : g_len
      AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (|len_in[LEN_IN_W-1:24]) ? (&len_out) : (len_out == len_in[23:0])); // R10
    end else begin : g_len_narrow
      AST_LEN_PASS: assert property (@(posedge clk) disable iff (!rst_sync_n)
        len_out == 24'(len_in)); // R10
    end
  endgenerate

endmodule

bind dma_addr_loader dal_checker #(
  .OFS_W     (OFS_W),
  .LEN_IN_W  (LEN_IN_W),
  .LATCH_OFS (LATCH_OFS)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_wr     (bus_wr),
  .bus_ofs    (bus_ofs),
  .len_in     (len_in),
  .len_out    (len_out),
  .load_done  (load_done),
  .dma_addr   (dma_addr),
  .dma_dir    (dma_dir),
  .seq_error  (seq_error),
  .armed      (armed)
);

// File: tb/dma_addr_loader_tb_top.sv
module dma_addr_loader_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;
  localparam int NVEC       = 6;

  // {word, expected byte address, expected direction}
  localparam logic [64:0] VEC [NVEC] = '{
    {32'h8000_0000, 32'h0000_0000, 1'b1},
    {32'h7FFF_FFFF, 32'hFFFF_FFFE, 1'b0},
    {32'h1234_5678, 32'h2468_ACF0, 1'b0},
    {32'hDEAD_BEEF, 32'hBD5B_7DDE, 1'b1},
    {32'h0000_0001, 32'h0000_0002, 1'b0},
    {32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b1}
  };

  logic        clk;
  logic        rst_n;
  logic        bus_wr    [2];
  logic [15:0] bus_ofs   [2];
  logic [7:0]  bus_wdata [2];
  logic [31:0] len_in;
  logic [23:0] len_out   [2];
  logic        load_done [2];
  logic [31:0] dma_addr  [2];
  logic        dma_dir   [2];
  logic        seq_error [2];

  int checks = 0;
  int errors = 0;

  dma_addr_loader #(.VARIANT(0)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .bus_wr (bus_wr[0]), .bus_ofs (bus_ofs[0]), .bus_wdata (bus_wdata[0]),
    .len_in (len_in), .len_out (len_out[0]),
    .load_done (load_done[0]), .dma_addr (dma_addr[0]),
    .dma_dir (dma_dir[0]), .seq_error (seq_error[0])
  );

  dma_addr_loader #(.VARIANT(1)) dut_v1_i (
    .clk (clk), .rst_n (rst_n),
    .bus_wr (bus_wr[1]), .bus_ofs (bus_ofs[1]), .bus_wdata (bus_wdata[1]),
    .len_in (len_in), .len_out (len_out[1]),
    .load_done (load_done[1]), .dma_addr (dma_addr[1]),
    .dma_dir (dma_dir[1]), .seq_error (seq_error[1])
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input int v, input logic [15:0] ofs, input logic [7:0] d);
    @(negedge clk);
    bus_wr[v]    = 1'b1;
    bus_ofs[v]   = ofs;
    bus_wdata[v] = d;
    @(negedge clk);
    bus_wr[v] = 1'b0;
  endtask

  function automatic logic [15:0] latch_ofs(input int v);
    return (v == 0) ? 16'h8000 : 16'h0010;
  endfunction

  // full load; returns at the negedge where load_done should be high
  task automatic load_word(input int v, input logic [31:0] w);
    bus_write(v, latch_ofs(v), w[31:24]);
    if (v == 0) bus_write(v, 16'h0000, w[31:24]);
    bus_write(v, 16'h0000, w[23:16]);
    bus_write(v, 16'h0000, w[15:8]);
    bus_write(v, 16'h0000, w[7:0]);
  endtask

  task automatic check_idle(input int v, input string req);
    check(req, $sformatf("v%0d load_done", v), 32'(load_done[v]), 32'd0);
    check(req, $sformatf("v%0d dma_addr", v), dma_addr[v], 32'd0);
    check(req, $sformatf("v%0d dma_dir", v), 32'(dma_dir[v]), 32'd0);
    check(req, $sformatf("v%0d seq_error", v), 32'(seq_error[v]), 32'd0);
  endtask

  // watchdog
  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    len_in = '0;
    for (int v = 0; v < 2; v++) begin
      bus_wr[v] = 1'b0; bus_ofs[v] = '0; bus_wdata[v] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check_idle(0, "R1");
    check_idle(1, "R1");

    // R7: orphan address byte before any latch (variant 1)
    bus_write(1, 16'h0000, 8'h5A);
    check("R7", "v1 orphan sets seq_error", 32'(seq_error[1]), 32'd1);
    check("R7", "v1 orphan leaves dma_addr", dma_addr[1], 32'd0);
    check("R7", "v1 orphan no load_done", 32'(load_done[1]), 32'd0);
    // R2: latch write clears the flag
    bus_write(1, 16'h0010, 8'h00);
    check("R2", "v1 latch clears seq_error", 32'(seq_error[1]), 32'd0);

    // table walk, both variants (R3, R4, R5)
    for (int i = 0; i < NVEC; i++) begin
      for (int v = 0; v < 2; v++) begin
        load_word(v, VEC[i][64:33]);
        check("R4", $sformatf("v%0d vec%0d load_done", v, i), 32'(load_done[v]), 32'd1);
        check("R5", $sformatf("v%0d vec%0d dma_addr", v, i), dma_addr[v], VEC[i][32:1]);
        check("R5", $sformatf("v%0d vec%0d dma_dir", v, i), 32'(dma_dir[v]), 32'(VEC[i][0]));
        @(negedge clk);
        check("R4", $sformatf("v%0d vec%0d strobe width", v, i), 32'(load_done[v]), 32'd0);
      end
    end

    // R6: outputs hold while idle
    repeat (5) @(negedge clk);
    check("R6", "v0 dma_addr held", dma_addr[0], 32'hFFFF_FFFE);
    check("R6", "v0 dma_dir held", 32'(dma_dir[0]), 32'd1);

    // R11: extra byte after a completed load
    bus_write(0, 16'h0000, 8'h55);
    check("R11", "v0 extra byte flags", 32'(seq_error[0]), 32'd1);
    check("R11", "v0 extra byte no strobe", 32'(load_done[0]), 32'd0);
    check("R11", "v0 extra byte leaves dma_addr", dma_addr[0], 32'hFFFF_FFFE);

    // R9: foreign offsets ignored mid-sequence; R3 count
    bus_write(0, 16'h8000, 8'h11);
    check("R2", "v0 latch clears seq_error", 32'(seq_error[0]), 32'd0);
    bus_write(0, 16'h0010, 8'hAA);
    bus_write(0, 16'h4000, 8'hBB);
    bus_write(0, 16'h0001, 8'hCC);
    check("R9", "v0 foreign offsets no strobe", 32'(load_done[0]), 32'd0);
    bus_write(0, 16'h0000, 8'h11);
    bus_write(0, 16'h0000, 8'h22);
    bus_write(0, 16'h0000, 8'h33);
    check("R3", "v0 no strobe after three bytes", 32'(load_done[0]), 32'd0);
    check("R9", "v0 dma_addr unchanged mid-load", dma_addr[0], 32'hFFFF_FFFE);
    bus_write(0, 16'h0000, 8'h44);
    check("R9", "v0 strobe on fourth byte", 32'(load_done[0]), 32'd1);
    check("R9", "v0 dma_addr after foreign writes", dma_addr[0], 32'h2244_6688);
    check("R9", "v0 seq_error untouched", 32'(seq_error[0]), 32'd0);

    // R3: repeated top byte overrides the latched one (variant 0)
    bus_write(0, 16'h8000, 8'h00);
    bus_write(0, 16'h0000, 8'h80);
    bus_write(0, 16'h0000, 8'h00);
    bus_write(0, 16'h0000, 8'h00);
    bus_write(0, 16'h0000, 8'h02);
    check("R3", "v0 top byte from address register dir", 32'(dma_dir[0]), 32'd1);
    check("R3", "v0 top byte from address register addr", dma_addr[0], 32'h0000_0004);

    // R8: abort by a latch write in the middle (variant 1)
    bus_write(1, 16'h0010, 8'h01);
    bus_write(1, 16'h0000, 8'h02);
    bus_write(1, 16'h0000, 8'h03);
    check("R8", "v1 partial load no strobe", 32'(load_done[1]), 32'd0);
    bus_write(1, 16'h0010, 8'h85);
    check("R8", "v1 re-latch no strobe", 32'(load_done[1]), 32'd0);
    bus_write(1, 16'h0000, 8'hA0);
    bus_write(1, 16'h0000, 8'hB0);
    check("R8", "v1 restarted count no early strobe", 32'(load_done[1]), 32'd0);
    bus_write(1, 16'h0000, 8'hC0);
    check("R8", "v1 restarted load strobe", 32'(load_done[1]), 32'd1);
    check("R8", "v1 restarted load dma_addr", dma_addr[1], 32'h0B41_6180);
    check("R8", "v1 restarted load dma_dir", 32'(dma_dir[1]), 32'd1);

    // R10: length limit
    len_in = 32'h00AB_CDEF; #1;
    check("R10", "len below limit", 32'(len_out[0]), 32'h00AB_CDEF);
    len_in = 32'h00FF_FFFF; #1;
    check("R10", "len at limit", 32'(len_out[0]), 32'h00FF_FFFF);
    len_in = 32'h0100_0000; #1;
    check("R10", "len just above limit", 32'(len_out[0]), 32'h00FF_FFFF);
    len_in = 32'hFFFF_FFFF; #1;
    check("R10", "len max input", 32'(len_out[1]), 32'h00FF_FFFF);

    // R1: asynchronous reset in the middle of a load
    bus_write(0, 16'h8000, 8'h12);
    bus_write(0, 16'h0000, 8'h12);
    rst_n = 1'b0;
    #1;
    check_idle(0, "R1");
    check_idle(1, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_idle(0, "R1");
    bus_write(0, 16'h0000, 8'h34);
    check("R1", "v0 load dropped by reset", 32'(seq_error[0]), 32'd1);
    check("R1", "v0 no strobe after reset", 32'(load_done[0]), 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule